// File: doc/BRIEF.md
# Multi-channel microsecond timer

This peripheral has four down-counting event timers and one up-counting 32-bit timestamp counter. All of them are driven by tick pulses derived from the input clock. A prescaler divides the clock by a parameter to make a 1 µs tick. A chain of three decade stages then makes 10 µs, 100 µs and 1 ms ticks from it.

Each event timer picks one of these ticks, counts down from a stored load value and pulses its own interrupt line when it expires. In periodic mode it reloads and keeps running. In one-shot mode it stops and clears its own enable bit. The timestamp counter runs all the time on its selected tick unless the hold bit freezes it. Software reads it to measure elapsed time.

The block is programmed through a simple write-strobe register bus. Reads are combinational and return data in the same cycle. A single control word holds every timebase select, mode bit and enable bit.

Top module: `multi_timer`

## Requirements
- R1: After reset the control word, every event count, the timestamp count and all interrupt outputs are zero.
- R2: Addresses are byte offsets. Offset 0x00 is the control word, offset (t+1)*4 is the load/count register of event timer t (t = 0..3), and offset 0x14 is the timestamp count. The control word reads back what was written, masked to its defined fields: [7:0], [10:8], [15:12], [19:16] and [20].
- R3: Writing a load register while its timer is disabled only stores the value. No interrupt follows, and a read of that offset returns the value.
- R4: With enable bit 16+t and periodic bit 12+t both set, timer t pulses its interrupt once every (load+1) selected ticks.
- R5: The event timebase field of timer t sits at bits [2t+1:2t]. Code 0 selects a 1 µs tick (CLK_PER_US clocks), 1 selects 10 µs, 2 selects 100 µs and 3 selects 1 ms.
- R6: In one-shot mode (periodic bit clear) the timer pulses its interrupt once, clears its enable bit at the same moment, and then raises no further interrupt.
- R7: An expiry of timer t pulses only irq[t], and the pulse is one clock wide.
- R8: The timestamp counter adds one per tick chosen by bits [10:8]: code 0 is the raw clock, 1 is 1 µs, 2 is 10 µs, 3 is 100 µs and 4 is 1 ms. Codes 5 to 7 give no ticks. The counter wraps modulo 2^32.
- R9: When bit 20 is set, the timestamp counter holds its value.
- R10: A write that changes enable bit 16+t from 0 to 1 starts the countdown from the stored load value. Interrupts occur only while the timer is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for addr |
| irq | output | 4 | One interrupt pulse line per event timer |

## Verification
Four behaviours are checked by properties on every cycle:
- the one-shot self-clear of the enable bit at expiry;
- the absence of interrupts from disabled timers;
- the freeze of the timestamp counter under the hold bit;
- its exact increment rate on the raw-clock timebase.

Interval lengths for each timebase and load value are shown only by the bench's scenarios. So are the independence of the four interrupt lines, the store-only behaviour of load writes, and the start-from-load timing.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  localparam int NEVT   = 4;
  localparam int LOAD_W = 16;
  localparam int DATA_W = 32;
  localparam int TS_W   = 32;
  localparam int ADDR_W = 5;
  localparam int IDX_W  = ADDR_W - 2;
  localparam int SEL_W  = 2;
  localparam int TSSEL_W = 3;
  localparam int TSSEL_LSB = 8;
  localparam int PER_LSB = 12;
  localparam int EN_LSB  = 16;
  localparam int HOLD_BIT = 20;
  localparam int DEC_STAGES = 3;
  localparam logic [3:0] DEC_MAX = 4'd9;
  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h001F_F7FF;

  typedef struct packed {
    logic raw;
    logic us;
    logic us10;
    logic us100;
    logic ms;
  } tick_t;

  typedef struct packed {
    logic [NEVT-1:0]       loadWr;
    logic [NEVT-1:0]       start;
    logic [NEVT-1:0]       run;
    logic [NEVT-1:0]       periodic;
    logic [SEL_W*NEVT-1:0] sel;
    logic [TSSEL_W-1:0]    tsSel;
    logic                  tsHold;
    logic [LOAD_W-1:0]     wrVal;
  } strobe_t;
endpackage

// File: rtl/mtmr_prescale.sv
module mtmr_prescale
  import mtmr_pkg::*;
#(
  parameter int CLK_PER_US = 100
) (
  input  logic  clk,
  input  logic  rstN,
  output tick_t ticks
);
  localparam int CW = $clog2(CLK_PER_US + 1);
  localparam logic [CW-1:0] US_LAST = CW'(CLK_PER_US - 1);

  logic [CW-1:0] usCnt;
  logic [DEC_STAGES:0] carry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) usCnt <= '0;
    else if (usCnt == US_LAST) usCnt <= '0;
    else usCnt <= usCnt + CW'(1);
  end

  assign carry[0] = (usCnt == US_LAST);

  for (genvar i = 0; i < DEC_STAGES; i++) begin : g_dec
    logic [3:0] decQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) decQ <= '0;
      else if (carry[i]) decQ <= (decQ == DEC_MAX) ? 4'd0 : decQ + 4'd1;
    end
    assign carry[i+1] = carry[i] && (decQ == DEC_MAX);
  end

  assign ticks.raw   = 1'b1;
  assign ticks.us    = carry[0];
  assign ticks.us10  = carry[1];
  assign ticks.us100 = carry[2];
  assign ticks.ms    = carry[3];
endmodule

// File: rtl/mtmr_ctrl.sv
module mtmr_ctrl
  import mtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NEVT-1:0]   expire,
  output logic [DATA_W-1:0] ctrlQ,
  output strobe_t           strb
);
  logic [IDX_W-1:0]  idx;
  logic              ctrlWr;
  logic [DATA_W-1:0] ctrlD;

  assign idx    = addr[ADDR_W-1:2];
  assign ctrlWr = wrEn && (idx == '0);

  always_comb begin
    ctrlD = ctrlQ;
    for (int t = 0; t < NEVT; t++)
      if (expire[t]) ctrlD[EN_LSB+t] = 1'b0;
    if (ctrlWr) ctrlD = wrData & CTRL_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else ctrlQ <= ctrlD;
  end

  for (genvar t = 0; t < NEVT; t++) begin : g_strb
    assign strb.loadWr[t] = wrEn && (idx == IDX_W'(t + 1));
    assign strb.start[t]  = ctrlWr && wrData[EN_LSB+t] && !ctrlQ[EN_LSB+t];
  end

  assign strb.run      = ctrlQ[EN_LSB +: NEVT];
  assign strb.periodic = ctrlQ[PER_LSB +: NEVT];
  assign strb.sel      = ctrlQ[SEL_W*NEVT-1:0];
  assign strb.tsSel    = ctrlQ[TSSEL_LSB +: TSSEL_W];
  assign strb.tsHold   = ctrlQ[HOLD_BIT];
  assign strb.wrVal    = wrData[LOAD_W-1:0];
endmodule

// File: rtl/mtmr_datapath.sv
module mtmr_datapath
  import mtmr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  tick_t                  ticks,
  input  strobe_t                strb,
  output logic [NEVT*LOAD_W-1:0] countFlat,
  output logic [TS_W-1:0]        tsCount,
  output logic [NEVT-1:0]        irq,
  output logic [NEVT-1:0]        expire
);
  for (genvar t = 0; t < NEVT; t++) begin : g_evt
    logic [LOAD_W-1:0] loadQ;
    logic [LOAD_W-1:0] countQ;
    logic              irqQ;
    logic              tk;
    logic              hit;

    always_comb begin
      case (strb.sel[SEL_W*t +: SEL_W])
        2'd0:    tk = ticks.us;
        2'd1:    tk = ticks.us10;
        2'd2:    tk = ticks.us100;
        default: tk = ticks.ms;
      endcase
    end

    assign hit       = strb.run[t] && tk && (countQ == '0);
    assign expire[t] = hit && !strb.periodic[t];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loadQ  <= '0;
        countQ <= '0;
        irqQ   <= 1'b0;
      end else begin
        irqQ <= hit;
        if (strb.loadWr[t]) loadQ <= strb.wrVal;
        if (strb.start[t]) countQ <= loadQ;
        else if (strb.run[t] && tk) begin
          if (countQ == '0) countQ <= strb.periodic[t] ? loadQ : '0;
          else countQ <= countQ - LOAD_W'(1);
        end else if (strb.loadWr[t] && !strb.run[t]) countQ <= strb.wrVal;
      end
    end

    assign countFlat[t*LOAD_W +: LOAD_W] = countQ;
    assign irq[t] = irqQ;
  end

  logic tsTick;
  always_comb begin
    case (strb.tsSel)
      3'd0:    tsTick = ticks.raw;
      3'd1:    tsTick = ticks.us;
      3'd2:    tsTick = ticks.us10;
      3'd3:    tsTick = ticks.us100;
      3'd4:    tsTick = ticks.ms;
      default: tsTick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tsCount <= '0;
    else if (tsTick && !strb.tsHold) tsCount <= tsCount + TS_W'(1);
  end
endmodule

// File: rtl/multi_timer.sv
module multi_timer
  import mtmr_pkg::*;
#(
  parameter int CLK_PER_US = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NEVT-1:0]   irq
);
  tick_t                  ticks;
  strobe_t                strb;
  logic [DATA_W-1:0]      ctrlQ;
  logic [NEVT-1:0]        expire;
  logic [NEVT*LOAD_W-1:0] countFlat;
  logic [TS_W-1:0]        tsCount;
  logic [IDX_W-1:0]       idx;

  mtmr_prescale #(.CLK_PER_US(CLK_PER_US)) pre_i (
    .clk(clk), .rstN(rstN), .ticks(ticks)
  );

  mtmr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .expire(expire), .ctrlQ(ctrlQ), .strb(strb)
  );

  mtmr_datapath dp_i (
    .clk(clk), .rstN(rstN), .ticks(ticks), .strb(strb),
    .countFlat(countFlat), .tsCount(tsCount), .irq(irq), .expire(expire)
  );

  assign idx = addr[ADDR_W-1:2];

  always_comb begin
    rdData = '0;
    if (idx == '0) rdData = ctrlQ;
    for (int t = 0; t < NEVT; t++)
      if (idx == IDX_W'(t + 1)) rdData = DATA_W'(countFlat[t*LOAD_W +: LOAD_W]);
    if (idx == IDX_W'(NEVT + 1)) rdData = DATA_W'(tsCount);
  end
endmodule

// File: rtl/multi_timer_chk.sv
module multi_timer_chk
  import mtmr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] ctrlQ,
  input logic [NEVT-1:0]   irq,
  input logic [TS_W-1:0]   tsCount
);
  for (genvar t = 0; t < NEVT; t++) begin : g_chk
    // R6
    oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (irq[t] && $past(rstN) && !$past(ctrlQ[PER_LSB+t]) && !$past(wrEn))
        |-> !ctrlQ[EN_LSB+t]);
    // R10
    irq_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
      (irq[t] && $past(rstN)) |-> $past(ctrlQ[EN_LSB+t]));
  end

  // R9
  ts_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(ctrlQ[HOLD_BIT])) |-> (tsCount == $past(tsCount)));

  // R8
  ts_raw_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ($past(ctrlQ[TSSEL_LSB +: TSSEL_W]) == 3'd0) && !$past(ctrlQ[HOLD_BIT]))
      |-> (tsCount == $past(tsCount) + 32'd1));
endmodule

bind multi_timer multi_timer_chk chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .ctrlQ(ctrlQ), .irq(irq), .tsCount(tsCount)
);

// File: tb/multi_timer_tb_top.sv
module multi_timer_tb_top;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  irq;
  int nChk = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  multi_timer #(.CLK_PER_US(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // {timer[1:0], timebase[1:0], load[15:0], period in clocks[31:0]}
  localparam int NV = 6;
  localparam logic [51:0] VEC [NV] = '{
    {2'd0, 2'd0, 16'd3, 32'd8},
    {2'd1, 2'd0, 16'd0, 32'd2},
    {2'd2, 2'd1, 16'd1, 32'd40},
    {2'd3, 2'd0, 16'd9, 32'd20},
    {2'd0, 2'd2, 16'd0, 32'd200},
    {2'd1, 2'd3, 16'd0, 32'd2000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic waitIrq(input int t, input int limit, output int cyc, output int others);
    cyc = 0;
    others = 0;
    while (!irq[t] && cyc < limit) begin
      @(negedge clk);
      cyc++;
      if ((irq & ~(4'b1 << t)) != 0) others++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    logic [31:0] v, a, b;
    int cyc, oth, cnt;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 irq", {28'd0, irq}, 32'd0);
    busRd(5'h00, v); check("R1 ctrl", v, 32'd0);
    busRd(5'h04, v); check("R1 count", v, 32'd0);
    busRd(5'h14, v); check("R1 ts", v, 32'd0);
    rstN = 1'b1;

    // R2 control readback with masking
    busWr(5'h00, 32'hFFE0_3905);
    busRd(5'h00, v); check("R2 ctrl readback", v, 32'h0000_3105);
    busWr(5'h00, 32'h0);

    // R4 R5 R7 periodic vectors
    for (int i = 0; i < NV; i++) begin
      int t;
      logic [1:0] sel;
      logic [15:0] ld;
      int per;
      t   = int'(VEC[i][51:50]);
      sel = VEC[i][49:48];
      ld  = VEC[i][47:32];
      per = int'(VEC[i][31:0]);
      busWr(5'((t + 1) * 4), {16'd0, ld});
      busWr(5'h00, (32'(sel) << (2 * t)) | (32'h1 << (16 + t)) | (32'h1 << (12 + t)));
      waitIrq(t, 5000, cyc, oth);
      @(negedge clk);
      check("R7 pulse width", {31'd0, irq[t]}, 32'd0);
      cyc = 1;
      while (!irq[t] && cyc < 5000) begin
        @(negedge clk);
        cyc++;
        if ((irq & ~(4'b1 << t)) != 0) oth++;
      end
      check("R4 R5 period", 32'(cyc), 32'(per));
      check("R7 other lines", 32'(oth), 32'd0);
      busWr(5'h00, 32'h0);
    end

    // R3 load write while disabled
    busWr(5'h10, 32'h0000_1234);
    cnt = 0;
    repeat (40) begin @(negedge clk); if (irq != 0) cnt++; end
    check("R3 no irq", 32'(cnt), 32'd0);
    busRd(5'h10, v); check("R3 readback", v, 32'h0000_1234);

    // R10 start from stored load: load 5 on 1us tick, irq 11..12 clocks after enable
    busWr(5'h08, 32'd5);
    busWr(5'h00, 32'h1 << 17);
    waitIrq(1, 100, cyc, oth);
    check("R10 start delay", {31'd0, (cyc >= 10 && cyc <= 13)}, 32'd1);

    // R6 one-shot on timer 2
    busWr(5'h00, 32'h0);
    busWr(5'h0C, 32'd4);
    busWr(5'h00, 32'h1 << 18);
    waitIrq(2, 100, cyc, oth);
    check("R6 fired", {31'd0, irq[2]}, 32'd1);
    @(negedge clk);
    busRd(5'h00, v); check("R6 enable cleared", {31'd0, v[18]}, 32'd0);
    cnt = 0;
    repeat (60) begin @(negedge clk); if (irq[2]) cnt++; end
    check("R6 no repeat", 32'(cnt), 32'd0);

    // R8 timestamp rates
    busWr(5'h00, 32'h0000_0000);
    busRd(5'h14, a); repeat (7) @(negedge clk); busRd(5'h14, b);
    check("R8 raw", b - a, 32'd7);
    busWr(5'h00, 32'h0000_0100);
    busRd(5'h14, a); repeat (20) @(negedge clk); busRd(5'h14, b);
    check("R8 1us", b - a, 32'd10);
    busWr(5'h00, 32'h0000_0200);
    busRd(5'h14, a); repeat (200) @(negedge clk); busRd(5'h14, b);
    check("R8 10us", b - a, 32'd10);
    busWr(5'h00, 32'h0000_0500);
    busRd(5'h14, a); repeat (50) @(negedge clk); busRd(5'h14, b);
    check("R8 unused code", b - a, 32'd0);

    // R9 hold
    busWr(5'h00, 32'h0010_0100);
    busRd(5'h14, a); repeat (40) @(negedge clk); busRd(5'h14, b);
    check("R9 hold", b - a, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule